// File: doc/BRIEF.md
# Buffered Up/Down Timer with Deferred Commands

This block is a free-running timer/counter core. It counts on a prescaler tick, up towards a period value or down towards zero, and wraps when it reaches that end. The period and each compare value sit in two layers. Software writes a buffer register, and the buffer is copied into the active register either when the counter wraps or when software forces the copy. The copy at a wrap is the hardware update.

Software controls the counter through a pair of control addresses. The set address raises the one-shot, lock-update and direction flags. The clear address lowers them. Both addresses read back the same value. A three-bit command field on the set address holds a command until the next prescaler tick. The tick runs the command and empties the field. The commands are retrigger, stop, forced update and a count snapshot. A state machine with three states tracks whether the counter is stopped, counting, or expired after a one-shot wrap.

Top module: `tmr_core`

Register map (word addresses): 0 control-set, 1 control-clear, 2 count snapshot (read only), 3 reads zero. Channel k uses two addresses: its buffer at 4+2k and its active value (read only) at 5+2k. Channel 0 is the period and channels 1..NUM_CC are the compares. Control byte layout: bits 7:5 command, bit 2 one-shot, bit 1 lock-update, bit 0 direction (1 = down). Bits 4:3 read zero. Command codes: 0 none, 1 retrigger, 2 stop, 3 forced update, 4 snapshot. Codes 5 to 7 are held and then dropped without effect.

State machine: states STOPPED (reset), COUNTING and EXPIRED. The transitions are:
- STOPPED→COUNTING on retrigger.
- COUNTING→COUNTING on retrigger (restart).
- COUNTING→STOPPED on stop.
- COUNTING→EXPIRED on a wrap while one-shot is set.
- EXPIRED→COUNTING on retrigger.
- EXPIRED→STOPPED on stop.

## Requirements
- R1: After reset the control byte reads 0x00, the count is 0, the state is STOPPED, the period buffer and active period hold all ones, and the compare registers hold zero.
- R2: On the set address, a 1 in bit 2, 1 or 0 raises that flag and a 0 leaves it alone. On the clear address, a 1 in those bits lowers the flag and a 0 leaves it alone. Both addresses return the same byte, and the command bits of a clear-address write are ignored.
- R3: A write of a nonzero command to bits 7:5 of the set address is held and reads back until the next tick. That tick executes it and the field then reads 0. A write of 0 to the field leaves a held command unchanged.
- R4: A retrigger enters COUNTING. It loads the count with 0 when the direction is up, or with the active period when the direction is down.
- R5: A stop enters STOPPED. The count then keeps its value through later ticks.
- R6: While counting up, each tick adds 1. A tick at a count equal to the active period wraps the count to 0 and pulses wrap_o for one cycle.
- R7: While counting down, each tick subtracts 1. A tick at count 0 reloads the active period in force before that tick and pulses wrap_o.
- R8: With one-shot set, a wrap still takes place, and the state then moves to EXPIRED. The count stays at the wrapped value until a retrigger.
- R9: At a wrap with lock-update clear, every buffer is copied into its active register. A write to a buffer alone never changes the active value.
- R10: With lock-update set, a wrap leaves the active registers unchanged, unless capture_en_i is high. With capture_en_i high, the copy happens anyway.
- R11: A forced-update command copies all buffers into the active registers on its tick, whatever the lock-update flag.
- R12: A snapshot command stores the count present at its tick (before that tick's step) into the snapshot register at address 2.
- R13: Without a tick, the count and the state do not change. Register writes only latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaler tick, one cycle wide |
| capture_en_i | input | 1 | Input-capture mode enable; overrides lock-update |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write word address |
| wr_data_i | input | BUS_W | Write data |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_data_o | output | BUS_W | Read data (combinational) |
| count_o | output | CNT_W | Current count |
| running_o | output | 1 | State is COUNTING |
| expired_o | output | 1 | State is EXPIRED |
| wrap_o | output | 1 | One-cycle pulse after a wrapping tick |

## Verification
The bench sweeps every period value of a 4-bit counter in both directions through two full wrap cycles. It compares each count with the modular arithmetic of the requirements. This sweep catches an off-by-one at the wrap end, a period-0 counter that never wraps, or a down count that reloads 0 instead of the period. Commands are checked for deferral to the tick and for self-clearing, so a design that acts at write time or never empties the field fails. Separate directed cases cover the following faults:
- a hardware copy that ignores lock-update, or that ignores the capture override;
- a forced update that obeys the lock;
- a one-shot counter that either keeps counting or stops before wrapping;
- a snapshot taken after the step instead of before it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CMD_W    = 3;
    localparam int CMD_LSB  = 5;
    localparam int OS_BIT   = 2;
    localparam int LUPD_BIT = 1;
    localparam int DIR_BIT  = 0;

    localparam logic [CMD_W-1:0] CMD_NONE   = 3'd0;
    localparam logic [CMD_W-1:0] CMD_RETRIG = 3'd1;
    localparam logic [CMD_W-1:0] CMD_STOP   = 3'd2;
    localparam logic [CMD_W-1:0] CMD_UPDATE = 3'd3;
    localparam logic [CMD_W-1:0] CMD_RSYNC  = 3'd4;

    localparam int A_CTL_SET = 0;
    localparam int A_CTL_CLR = 1;
    localparam int A_SNAP    = 2;
    localparam int A_CH_BASE = 4;

    typedef enum logic [1:0] {
        S_STOPPED  = 2'd0,
        S_COUNTING = 2'd1,
        S_EXPIRED  = 2'd2
    } run_state_e;

endpackage

// File: rtl/tmr_ctl.sv
module tmr_ctl
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CMD_W-1:0]  wr_cmd_i,
    input  logic              wr_os_i,
    input  logic              wr_lupd_i,
    input  logic              wr_dir_i,
    output logic [CMD_W-1:0]  cmd_pend_o,
    output logic [CMD_W-1:0]  exec_cmd_o,
    output logic              oneshot_o,
    output logic              lupd_o,
    output logic              dir_o
);

    logic wr_set;
    logic wr_clr;

    assign wr_set = wr_en_i && (wr_addr_i == ADDR_W'(A_CTL_SET));
    assign wr_clr = wr_en_i && (wr_addr_i == ADDR_W'(A_CTL_CLR));

    // Held command: a fresh nonzero write wins over the tick that empties it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_pend_o <= CMD_NONE;
        end else if (wr_set && (wr_cmd_i != CMD_NONE)) begin
            cmd_pend_o <= wr_cmd_i;
        end else if (tick_i) begin
            cmd_pend_o <= CMD_NONE;
        end
    end

    // Flags: set address raises, clear address lowers, zeros leave alone
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oneshot_o <= 1'b0;
            lupd_o    <= 1'b0;
            dir_o     <= 1'b0;
        end else if (wr_set) begin
            if (wr_os_i)   oneshot_o <= 1'b1;
            if (wr_lupd_i) lupd_o    <= 1'b1;
            if (wr_dir_i)  dir_o     <= 1'b1;
        end else if (wr_clr) begin
            if (wr_os_i)   oneshot_o <= 1'b0;
            if (wr_lupd_i) lupd_o    <= 1'b0;
            if (wr_dir_i)  dir_o     <= 1'b0;
        end
    end

    assign exec_cmd_o = tick_i ? cmd_pend_o : CMD_NONE;

endmodule

// File: rtl/tmr_fsm.sv
module tmr_fsm
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CMD_W-1:0] exec_cmd_i,
    input  logic             dir_i,
    input  logic             oneshot_i,
    input  logic [CNT_W-1:0] per_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] snap_o,
    output logic             running_o,
    output logic             expired_o,
    output logic             wrap_evt_o,
    output logic             wrap_o
);

    run_state_e       state;
    run_state_e       state_nxt;
    logic             do_retrig;
    logic             do_stop;
    logic             do_step;
    logic             at_end;
    logic [CNT_W-1:0] start_val;
    logic [CNT_W-1:0] count_nxt;

    assign do_retrig = (exec_cmd_i == CMD_RETRIG);
    assign do_stop   = (exec_cmd_i == CMD_STOP);
    assign at_end    = dir_i ? (count_o == '0) : (count_o == per_i);
    assign start_val = dir_i ? per_i : '0;
    assign do_step   = tick_i && (state == S_COUNTING) && !do_retrig && !do_stop;
    assign wrap_evt_o = do_step && at_end;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_STOPPED;
        else        state <= state_nxt;
    end

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_STOPPED: begin
                if (do_retrig) state_nxt = S_COUNTING;
            end
            S_COUNTING: begin
                if (do_stop)                       state_nxt = S_STOPPED;
                else if (wrap_evt_o && oneshot_i)  state_nxt = S_EXPIRED;
            end
            S_EXPIRED: begin
                if (do_retrig)    state_nxt = S_COUNTING;
                else if (do_stop) state_nxt = S_STOPPED;
            end
            default: state_nxt = S_STOPPED;
        endcase
    end

    // Next count
    always_comb begin
        count_nxt = count_o;
        if (do_retrig) begin
            count_nxt = start_val;
        end else if (do_step) begin
            if (at_end)     count_nxt = start_val;
            else if (dir_i) count_nxt = count_o - 1'b1;
            else            count_nxt = count_o + 1'b1;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            snap_o  <= '0;
            wrap_o  <= 1'b0;
        end else begin
            count_o <= count_nxt;
            wrap_o  <= wrap_evt_o;
            if (exec_cmd_i == CMD_RSYNC) snap_o <= count_o;
        end
    end

    assign running_o = (state == S_COUNTING);
    assign expired_o = (state == S_EXPIRED);

endmodule

// File: rtl/tmr_bufs.sv
module tmr_bufs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 4,
    parameter int NUM_CH = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            wr_addr_i,
    input  logic [CNT_W-1:0]             wr_data_i,
    input  logic                         copy_i,
    output logic [NUM_CH-1:0][CNT_W-1:0] buf_o,
    output logic [NUM_CH-1:0][CNT_W-1:0] act_o
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [CNT_W-1:0]  RST_V  = (ch == 0) ? {CNT_W{1'b1}} : {CNT_W{1'b0}};
        localparam logic [ADDR_W-1:0] BUF_AD = ADDR_W'(A_CH_BASE + 2 * ch);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                buf_o[ch] <= RST_V;
                act_o[ch] <= RST_V;
            end else begin
                if (wr_en_i && (wr_addr_i == BUF_AD)) buf_o[ch] <= wr_data_i;
                if (copy_i)                            act_o[ch] <= buf_o[ch];
            end
        end
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int NUM_CC = 2,
    parameter int ADDR_W = 4,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              capture_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BUS_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [BUS_W-1:0]  rd_data_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              running_o,
    output logic              expired_o,
    output logic              wrap_o
);

    localparam int NUM_CH = NUM_CC + 1;

    logic [CMD_W-1:0]              cmd_pend;
    logic [CMD_W-1:0]              exec_cmd;
    logic                          oneshot;
    logic                          lupd;
    logic                          dir;
    logic                          wrap_evt;
    logic                          copy;
    logic [CNT_W-1:0]              snap;
    logic [NUM_CH-1:0][CNT_W-1:0]  bufs;
    logic [NUM_CH-1:0][CNT_W-1:0]  act;
    logic [7:0]                    ctl_byte;

    tmr_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_cmd_i   (wr_data_i[CMD_LSB +: CMD_W]),
        .wr_os_i    (wr_data_i[OS_BIT]),
        .wr_lupd_i  (wr_data_i[LUPD_BIT]),
        .wr_dir_i   (wr_data_i[DIR_BIT]),
        .cmd_pend_o (cmd_pend),
        .exec_cmd_o (exec_cmd),
        .oneshot_o  (oneshot),
        .lupd_o     (lupd),
        .dir_o      (dir)
    );

    tmr_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .exec_cmd_i (exec_cmd),
        .dir_i      (dir),
        .oneshot_i  (oneshot),
        .per_i      (act[0]),
        .count_o    (count_o),
        .snap_o     (snap),
        .running_o  (running_o),
        .expired_o  (expired_o),
        .wrap_evt_o (wrap_evt),
        .wrap_o     (wrap_o)
    );

    // Hardware copy at a wrap (gated by lock unless capturing) or forced copy
    assign copy = (exec_cmd == CMD_UPDATE) || (wrap_evt && (!lupd || capture_en_i));

    tmr_bufs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_bufs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i[CNT_W-1:0]),
        .copy_i    (copy),
        .buf_o     (bufs),
        .act_o     (act)
    );

    assign ctl_byte = {cmd_pend, 2'b00, oneshot, lupd, dir};

    always_comb begin
        rd_data_o = '0;
        if ((rd_addr_i == ADDR_W'(A_CTL_SET)) || (rd_addr_i == ADDR_W'(A_CTL_CLR))) begin
            rd_data_o = BUS_W'(ctl_byte);
        end else if (rd_addr_i == ADDR_W'(A_SNAP)) begin
            rd_data_o = BUS_W'(snap);
        end
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (rd_addr_i == ADDR_W'(A_CH_BASE + 2 * ch))     rd_data_o = BUS_W'(bufs[ch]);
            if (rd_addr_i == ADDR_W'(A_CH_BASE + 2 * ch + 1)) rd_data_o = BUS_W'(act[ch]);
        end
    end

endmodule

module tmr_core_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              capture_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CMD_W-1:0]  wr_cmd,
    input logic [CMD_W-1:0]  cmd_pend,
    input logic              dir,
    input logic              lupd,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  per_act,
    input logic              running
);

    logic new_cmd;
    assign new_cmd = wr_en && (wr_addr == ADDR_W'(A_CTL_SET)) && (wr_cmd != CMD_NONE);

    p_cmd_selfclear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cmd_pend != CMD_NONE) && !new_cmd) |=> (cmd_pend == CMD_NONE));

    p_cmd_zero_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == ADDR_W'(A_CTL_SET)) && (wr_cmd == CMD_NONE) && !tick)
        |=> $stable(cmd_pend));

    p_no_tick_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(count) && $stable(running)));

    p_stopped_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(tick && (cmd_pend == CMD_RETRIG))) |=> $stable(count));

    p_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lupd && !capture_en && (cmd_pend != CMD_UPDATE)) |=> $stable(per_act));

    p_up_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && running && (cmd_pend == CMD_NONE) && !dir && (count != per_act))
        |=> (count == CNT_W'($past(count) + 1'b1)));

    p_down_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && running && (cmd_pend == CMD_NONE) && dir && (count != '0))
        |=> (count == CNT_W'($past(count) - 1'b1)));

endmodule

bind tmr_core tmr_core_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_i),
    .capture_en (capture_en_i),
    .wr_en      (wr_en_i),
    .wr_addr    (wr_addr_i),
    .wr_cmd     (wr_data_i[7:5]),
    .cmd_pend   (cmd_pend),
    .dir        (dir),
    .lupd       (lupd),
    .count      (count_o),
    .per_act    (act[0]),
    .running    (running_o)
);

// File: tb/tmr_core_test.sv
`timescale 1ns/1ps
module tmr_core_test;

    localparam int CW = 4;
    localparam int AW = 4;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tick_i;
    logic          capture_en_i;
    logic          wr_en_i;
    logic [AW-1:0] wr_addr_i;
    logic [BW-1:0] wr_data_i;
    logic [AW-1:0] rd_addr_i;
    logic [BW-1:0] rd_data_o;
    logic [CW-1:0] count_o;
    logic          running_o;
    logic          expired_o;
    logic          wrap_o;

    int vecs = 0;
    int bad  = 0;
    int v;

    always #2.5 clk = ~clk;

    tmr_core #(.CNT_W(CW), .NUM_CC(2), .ADDR_W(AW), .BUS_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .capture_en_i(capture_en_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .count_o(count_o),
        .running_o(running_o), .expired_o(expired_o), .wrap_o(wrap_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic we, input int a, input int d);
        tick_i    = t;
        wr_en_i   = we;
        wr_addr_i = AW'(a);
        wr_data_i = BW'(d);
        @(negedge clk);
        tick_i  = 1'b0;
        wr_en_i = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        cyc(1'b0, 1'b1, a, d);
    endtask

    task automatic tk();
        cyc(1'b1, 1'b0, 0, 0);
    endtask

    task automatic rd(input int a, output int val);
        rd_addr_i = AW'(a);
        #1;
        val = int'(rd_data_o);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick_i = 1'b0; capture_en_i = 1'b0; wr_en_i = 1'b0;
        wr_addr_i = '0; wr_data_i = '0; rd_addr_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk("R1 ctl", v, 0);
        chk("R1 count", count_o, 0);
        chk("R1 running", running_o, 0);
        chk("R1 expired", expired_o, 0);
        rd(4, v); chk("R1 period buf", v, 15);
        rd(5, v); chk("R1 period act", v, 15);
        rd(7, v); chk("R1 cc0 act", v, 0);

        // R2 set / clear semantics
        wr(0, 8'h00); rd(0, v); chk("R2 zero write", v, 0);
        wr(0, 8'h07); rd(0, v); chk("R2 set all", v, 7);
        rd(1, v); chk("R2 clr addr readback", v, 7);
        wr(0, 8'h00); rd(0, v); chk("R2 zero set keeps", v, 7);
        wr(1, 8'h02); rd(0, v); chk("R2 clear lupd", v, 5);
        wr(1, 8'h00); rd(0, v); chk("R2 zero clear keeps", v, 5);
        wr(1, 8'hE0); rd(0, v); chk("R2 clr cmd ignored", v, 5);
        wr(1, 8'h07); rd(0, v); chk("R2 clear all", v, 0);

        // R3 command deferral and self-clear; R13 no tick no change
        wr(0, 8'h20); rd(0, v); chk("R3 held retrig", v, 8'h20);
        wr(0, 8'h00); rd(0, v); chk("R3 zero keeps held", v, 8'h20);
        cyc(1'b0, 1'b0, 0, 0); cyc(1'b0, 1'b0, 0, 0);
        chk("R13 no tick not started", running_o, 0);
        tk(); rd(0, v); chk("R3 self clear", v, 0);
        chk("R3 executed", running_o, 1);
        wr(0, 8'h40); tk(); chk("R5 stop state", running_o, 0);
        wr(0, 8'hA0); rd(0, v); chk("R3 code5 held", v, 8'hA0);
        tk(); rd(0, v); chk("R3 code5 dropped", v, 0);
        chk("R3 code5 no effect", running_o, 0);

        // R4 R6 R7 R11 sweep over all periods and both directions
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 16; p++) begin
                wr(4, p);
                wr(1, 1);
                if (d == 1) wr(0, 1);
                wr(0, 8'h60); tk();
                rd(5, v); chk("R11 forced period", v, p);
                wr(0, 8'h20); tk();
                chk("R4 retrigger load", count_o, (d == 1) ? p : 0);
                chk("R4 running", running_o, 1);
                for (int k = 1; k <= 2 * (p + 1); k++) begin
                    tk();
                    if (d == 1) chk("R7 down count", count_o, p - (k % (p + 1)));
                    else        chk("R6 up count", count_o, k % (p + 1));
                    chk("R6 R7 wrap pulse", wrap_o, ((k % (p + 1)) == 0) ? 1 : 0);
                end
                wr(0, 8'h40); tk();
                chk("R5 stopped", running_o, 0);
                tk(); tk();
                chk("R5 hold", count_o, (d == 1) ? p : 0);
            end
        end
        wr(1, 8'h07);

        // R8 one-shot, up direction, period 3
        wr(4, 3); wr(0, 8'h60); tk();
        wr(0, 8'h04); wr(0, 8'h20); tk();
        tk(); tk(); tk();
        chk("R8 up before wrap", count_o, 3);
        chk("R8 still running", running_o, 1);
        tk();
        chk("R8 wrapped value", count_o, 0);
        chk("R8 expired", expired_o, 1);
        chk("R8 not running", running_o, 0);
        tk(); tk();
        chk("R8 stays", count_o, 0);
        wr(0, 8'h20); tk();
        chk("R8 retrigger restarts", running_o, 1);
        wr(0, 8'h40); tk();
        // R8 one-shot, down direction
        wr(0, 8'h01); wr(0, 8'h20); tk();
        chk("R8 down load", count_o, 3);
        tk(); tk(); tk(); tk();
        chk("R8 down wrapped", count_o, 3);
        chk("R8 down expired", expired_o, 1);
        tk();
        chk("R8 down stays", count_o, 3);
        wr(0, 8'h40); tk();
        wr(1, 8'h07);

        // R9 hardware copy at wrap, unlocked
        wr(0, 8'h20); tk();
        wr(4, 5); wr(6, 9);
        tk(); tk(); tk();
        rd(5, v); chk("R9 buffer write alone", v, 3);
        tk();
        rd(5, v); chk("R9 period copied", v, 5);
        rd(7, v); chk("R9 cc0 copied", v, 9);
        chk("R9 count wrapped", count_o, 0);

        // R10 locked copy suppressed
        wr(0, 8'h02); wr(4, 7);
        repeat (5) tk();
        chk("R10 counts to old period", count_o, 5);
        tk();
        chk("R10 wraps at old period", count_o, 0);
        rd(5, v); chk("R10 lock holds period", v, 5);
        // R10 capture override
        capture_en_i = 1'b1;
        repeat (6) tk();
        rd(5, v); chk("R10 capture overrides lock", v, 7);
        capture_en_i = 1'b0;

        // R11 forced update under lock, also compares
        wr(4, 2); wr(8, 11);
        wr(0, 8'h60); tk();
        rd(5, v); chk("R11 forced under lock", v, 2);
        rd(9, v); chk("R11 cc1 forced", v, 11);
        chk("R11 step on update tick", count_o, 1);

        // R12 snapshot before step
        wr(0, 8'h80); tk();
        rd(2, v); chk("R12 snapshot", v, 1);
        chk("R12 count advanced", count_o, 2);

        // R13 no tick, no motion while counting
        cyc(1'b0, 1'b0, 0, 0); cyc(1'b0, 1'b0, 0, 0); cyc(1'b0, 1'b0, 0, 0);
        chk("R13 count frozen", count_o, 2);
        chk("R13 still running", running_o, 1);
        tk();
        chk("R13 wrap after tick", count_o, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule